// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for the two-wire PHY management bus defined by IEEE 802.3 clause 22. Software programs a control register with an enable bit, a preamble-suppress bit and an 8-bit clock divider. A single write to the command register then launches one complete read or write frame to an external PHY. The block generates the management clock (MDC) from the system clock. It drives the data line through an output value and an output enable, so the pad can be tristated. It samples the PHY's answer on the rising MDC edge.

While a frame is in flight, the command register's go bit reads back 1. It falls to 0 on the same clock edge that ends the frame. For a read, the 16 data bits the PHY returned replace the data field of that register on that edge. A 32-bit presence mask holds one bit per PHY address. Every read updates the bit of the addressed PHY from the level seen in the second turnaround bit: a PHY that pulls the line low there is marked present, and a bus left high marks it absent.

Register reads are registered: `reg_rdata` shows the register selected by `reg_addr` one clock edge later. The register map is: address 0 control, address 1 command, address 2 presence mask, address 3 reads zero.

Top module: `mdio_master`

## Requirements
- R1: After synchronous reset, control reads 0x8000_0000 (idle set, disabled, preamble on, divider 0), command reads 0, presence mask reads 0, and `mdc` and `mdio_oe` are 0.
- R2: Control bit 30 (enable), bit 20 (preamble suppress) and bits 7:0 (divider) read back as written. All other bits read 0, except bit 31, which reads 1 when no frame is running and 0 while one is.
- R3: A command write is accepted when bit 31 is 1, the block is enabled and no frame is running. The command register then reads bit 31 = 1, bit 30 = write flag, bits 25:21 = register address, bits 20:16 = PHY address and bits 15:0 = data. Bit 31 clears exactly N·P clock edges after the accepting edge, where N is 64 with the preamble or 32 without it, and P = max(div,1)+1. The frame has exactly N rising MDC edges.
- R4: `mdc` is 0 while no frame runs. Within a frame, each MDC period is P clock cycles: high for P/2 cycles (rounded down) and low for the remainder.
- R5: A write frame is sent MSB first as: 32 ones (omitted when control bit 20 is 1), then 01, opcode 01, the 5-bit PHY address, the 5-bit register address, 10, and the 16 data bits. `mdio_o` changes only on falling MDC and `mdio_oe` is 1 for the whole frame.
- R6: A read frame uses opcode 10. `mdio_oe` is 0 for its last 18 bit times (turnaround and data). The 16 bits sampled on the rising MDC edges of the data phase, MSB first, appear in command bits 15:0 when bit 31 clears.
- R7: A read sets presence bit [PHY address] if `mdio_i` was 0 at the second turnaround bit, and clears that bit otherwise. A write leaves the mask unchanged.
- R8: While a frame is running, writes to the command register and the control register are ignored: the running frame, the command fields and the control fields all stay unchanged.
- R9: A command write with bit 31 clear, or any command write while the enable bit is 0, starts no frame and leaves the command register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register, one cycle after `reg_addr` |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| mdio_i | input | 1 | Management data seen at the pad |

## Verification
Every register value is due one edge after its address is presented, so the bench changes `reg_addr` on a falling clock edge and samples `reg_rdata` on the next falling edge. For each frame the bench computes the completion edge N·P from the divider and the preamble setting. It samples the command register after edge N·P, where busy must still be 1, and again after edge N·P+1, where busy must be 0 and the read data must be present. Frame bits, output enable and MDC high and low widths are collected on MDC and clock edges by a bench PHY model and compared after completion. That PHY model drives `mdio_i` on falling MDC, well before the next rising edge at which the design samples it.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam logic [5:0] IDX_TA0   = 6'd46;
  localparam logic [5:0] IDX_TA1   = 6'd47;
  localparam logic [5:0] IDX_DATA  = 6'd48;
  localparam logic [5:0] IDX_LAST  = 6'd63;
  localparam logic [5:0] IDX_NOPRE = 6'd32;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_CMD   = 2'd1;
  localparam logic [1:0] ADDR_ALIVE = 2'd2;

  localparam int BIT_GO    = 31;
  localparam int BIT_WR    = 30;
  localparam int BIT_IDLE  = 31;
  localparam int BIT_EN    = 30;
  localparam int BIT_NOPRE = 20;

  typedef struct packed {
    logic        wr;
    logic [4:0]  regad;
    logic [4:0]  phy;
    logic [15:0] data;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  localparam int CW = DIV_W + 1;

  logic [CW-1:0] per, hi_len, lo_len, cnt, lim;
  logic          tick;

  always_comb begin
    per    = (div == '0) ? CW'(2) : ({1'b0, div} + CW'(1));
    hi_len = per >> 1;
    lo_len = per - hi_len;
    lim    = (mdc ? hi_len : lo_len) - CW'(1);
    tick   = run && (cnt == lim);
  end

  assign rise = tick && !mdc;
  assign fall = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  mdio_cmd_t   cmd,
  input  logic        skip_pre,
  input  logic        rise,
  input  logic        fall,
  input  logic        mdio_i,
  output logic        active,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        responded
);
  logic [FRAME_BITS-1:0] frame_q, full;
  logic [5:0]            idx_q, idx_nx;
  logic                  rd_q;
  logic [15:0]           shin_q;

  always_comb begin
    full = {32'hFFFF_FFFF, 2'b01, (cmd.wr ? 2'b01 : 2'b10), cmd.phy, cmd.regad,
            (cmd.wr ? 2'b10 : 2'b11), (cmd.wr ? cmd.data : 16'hFFFF)};
    idx_nx = idx_q + 6'd1;
  end

  assign done    = active && fall && (idx_q == IDX_LAST);
  assign mdio_o  = frame_q[FRAME_BITS-1];
  assign rd_data = shin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      frame_q   <= '0;
      idx_q     <= '0;
      rd_q      <= 1'b0;
      shin_q    <= '0;
      responded <= 1'b0;
      mdio_oe   <= 1'b0;
    end else if (start) begin
      active    <= 1'b1;
      rd_q      <= !cmd.wr;
      frame_q   <= skip_pre ? {full[PRE_BITS-1:0], {PRE_BITS{1'b0}}} : full;
      idx_q     <= skip_pre ? IDX_NOPRE : 6'd0;
      shin_q    <= '0;
      responded <= 1'b0;
      mdio_oe   <= 1'b1;
    end else if (active) begin
      if (rise) begin
        if (rd_q && idx_q == IDX_TA1) responded <= !mdio_i;
        if (rd_q && idx_q >= IDX_DATA) shin_q <= {shin_q[14:0], mdio_i};
      end
      if (fall) begin
        if (idx_q == IDX_LAST) begin
          active  <= 1'b0;
          mdio_oe <= 1'b0;
          frame_q <= '0;
        end else begin
          idx_q   <= idx_nx;
          frame_q <= {frame_q[FRAME_BITS-2:0], 1'b0};
          mdio_oe <= !(rd_q && idx_nx >= IDX_TA0);
        end
      end
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic             busy,
  input  logic             done,
  input  logic [15:0]      rd_data,
  input  logic             responded,
  output logic [31:0]      reg_rdata,
  output logic             start,
  output mdio_cmd_t        cmd_in,
  output mdio_cmd_t        held_cmd,
  output logic             skip_pre,
  output logic             ctrl_en,
  output logic [DIV_W-1:0] div
);
  logic [31:0] alive_q, rd_v;
  logic        unused_wbits;

  assign unused_wbits = ^reg_wdata;
  assign cmd_in   = '{wr: reg_wdata[BIT_WR], regad: reg_wdata[25:21],
                      phy: reg_wdata[20:16], data: reg_wdata[15:0]};
  assign start    = reg_wr && (reg_addr == ADDR_CMD) && reg_wdata[BIT_GO] && ctrl_en && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en  <= 1'b0;
      skip_pre <= 1'b0;
      div      <= '0;
      held_cmd <= '0;
      alive_q  <= '0;
    end else begin
      if (reg_wr && reg_addr == ADDR_CTRL && !busy) begin
        ctrl_en  <= reg_wdata[BIT_EN];
        skip_pre <= reg_wdata[BIT_NOPRE];
        div      <= reg_wdata[DIV_W-1:0];
      end
      if (start) held_cmd <= cmd_in;
      if (done && !held_cmd.wr) begin
        held_cmd.data          <= rd_data;
        alive_q[held_cmd.phy]  <= responded;
      end
    end
  end

  always_comb begin
    rd_v = '0;
    case (reg_addr)
      ADDR_CTRL: begin
        rd_v[BIT_IDLE]    = !busy;
        rd_v[BIT_EN]      = ctrl_en;
        rd_v[BIT_NOPRE]   = skip_pre;
        rd_v[DIV_W-1:0]   = div;
      end
      ADDR_CMD: begin
        rd_v[BIT_GO]  = busy;
        rd_v[BIT_WR]  = held_cmd.wr;
        rd_v[25:21]   = held_cmd.regad;
        rd_v[20:16]   = held_cmd.phy;
        rd_v[15:0]    = held_cmd.data;
      end
      ADDR_ALIVE: rd_v = alive_q;
      default:    rd_v = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_v;
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic             busy, done, start, skip_pre, ctrl_en, rise, fall, responded;
  logic [15:0]      rd_data;
  logic [DIV_W-1:0] div;
  mdio_cmd_t        cmd_in, held_cmd;

  mdio_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .responded(responded),
    .reg_rdata(reg_rdata), .start(start), .cmd_in(cmd_in), .held_cmd(held_cmd),
    .skip_pre(skip_pre), .ctrl_en(ctrl_en), .div(div)
  );

  mdio_clkdiv #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .run(busy), .div(div), .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_shifter u_shift (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd_in), .skip_pre(skip_pre),
    .rise(rise), .fall(fall), .mdio_i(mdio_i), .active(busy), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .done(done), .rd_data(rd_data), .responded(responded)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      mdc,
  input logic      mdio_o,
  input logic      mdio_oe,
  input logic      busy,
  input logic      ctrl_en,
  input mdio_cmd_t held_cmd
);
  assert_mdc_idle_low_R4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

  assert_oe_in_frame_R5: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> busy);

  assert_data_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));

  assert_cmd_held_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(held_cmd));

  assert_no_start_disabled_R9: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_en && !busy) |=> !busy);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst(rst), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy), .ctrl_en(ctrl_en), .held_cmd(held_cmd)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #5 clk = ~clk;

  mdio_master u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int checks = 0;
  int errors = 0;

  // bench PHY model
  logic        phy_resp = 1'b0;
  logic [15:0] phy_data = '0;
  int          base_idx = 0;
  int          nrise = 0;
  logic [63:0] cap_d = '0, cap_oe = '0;
  int          hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0;
  logic [31:0] alive_exp = '0;

  always @(posedge mdc) begin
    cap_d  = {cap_d[62:0], mdio_o};
    cap_oe = {cap_oe[62:0], mdio_oe};
    nrise  = nrise + 1;
  end

  always @(negedge mdc) begin
    int i;
    i = base_idx + nrise;
    if (phy_resp && i == 47) mdio_i = 1'b0;
    else if (phy_resp && i >= 48 && i <= 63) mdio_i = phy_data[63 - i];
    else mdio_i = 1'b1;
  end

  always @(posedge clk) begin
    if (mdc) begin
      if (lo_run > 0) last_lo = lo_run;
      lo_run = 0;
      hi_run = hi_run + 1;
    end else begin
      if (hi_run > 0) last_hi = hi_run;
      hi_run = 0;
      lo_run = lo_run + 1;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  function automatic logic [63:0] exp_frame(bit wr, logic [4:0] phy, logic [4:0] ra, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, ra, (wr ? 2'b10 : 2'b11),
            (wr ? d : 16'hFFFF)};
  endfunction

  function automatic int period(int div);
    return ((div == 0) ? 1 : div) + 1;
  endfunction

  function automatic logic [31:0] cmd_word(bit go, bit wr, logic [4:0] phy, logic [4:0] ra, logic [15:0] d);
    return {go, wr, 4'b0, ra, phy, d};
  endfunction

  task automatic prep_phy(bit resp, logic [15:0] pd, bit skip);
    phy_resp = resp; phy_data = pd; base_idx = skip ? 32 : 0;
    nrise = 0; cap_d = '0; cap_oe = '0; mdio_i = 1'b1;
  endtask

  task automatic check_frame(bit wr, logic [4:0] phy, logic [4:0] ra, logic [15:0] d, int n);
    logic [63:0] m, e, eoe;
    m   = (n == 64) ? '1 : 64'h0000_0000_FFFF_FFFF;
    e   = exp_frame(wr, phy, ra, d);
    eoe = '1;
    if (!wr) begin
      m   = m & ~64'h3FFFF;
      eoe = ~64'h3FFFF;
      chk("R6 read frame bits", cap_d & m, e & m);
      chk("R6 read oe pattern", cap_oe & ((n == 64) ? '1 : 64'hFFFF_FFFF), eoe & ((n == 64) ? '1 : 64'hFFFF_FFFF));
    end else begin
      chk("R5 write frame bits", cap_d & m, e & m);
      chk("R5 write oe pattern", cap_oe & m, eoe & m);
    end
  endtask

  task automatic txn(bit wr, logic [4:0] phy, logic [4:0] ra, logic [15:0] d,
                     bit resp, logic [15:0] pd, int div, bit skip);
    int n, k;
    logic [31:0] v;
    wr_reg(2'd0, 32'h4000_0000 | (32'(skip) << 20) | 32'(div));
    prep_phy(resp, pd, skip);
    n = skip ? 32 : 64;
    k = n * period(div);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = cmd_word(1'b1, wr, phy, ra, d);
    @(negedge clk);
    reg_wr = 1'b0;
    repeat (k) @(negedge clk);
    chk("R3 busy still set at last edge", 64'(reg_rdata[31]), 64'd1);
    @(negedge clk);
    v = reg_rdata;
    chk("R3 busy cleared after N*P edges", 64'(v[31]), 64'd0);
    chk("R3 fields read back", 64'({v[30], v[25:16]}), 64'({wr, ra, phy}));
    chk("R3 rising MDC count", 64'(nrise), 64'(n));
    if (wr) begin
      chk("R5 data field after write", 64'(v[15:0]), 64'(d));
    end else begin
      chk("R6 read data", 64'(v[15:0]), 64'(resp ? pd : 16'hFFFF));
      alive_exp[phy] = resp;
    end
    check_frame(wr, phy, ra, d, n);
    rd_reg(2'd2, v);
    chk("R7 presence mask", 64'(v), 64'(alive_exp));
  endtask

  initial begin
    logic [31:0] v;
    int seed_use;
    seed_use = $urandom(32'h5EED_1234);
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 mdc low", 64'(mdc), 64'd0);
    chk("R1 oe low", 64'(mdio_oe), 64'd0);
    rd_reg(2'd0, v); chk("R1 control", 64'(v), 64'h8000_0000);
    rd_reg(2'd1, v); chk("R1 command", 64'(v), 64'd0);
    rd_reg(2'd2, v); chk("R1 presence", 64'(v), 64'd0);

    // R2 control readback
    wr_reg(2'd0, 32'h4010_00A5);
    rd_reg(2'd0, v); chk("R2 control readback", 64'(v), 64'hC010_00A5);
    wr_reg(2'd0, 32'hFFFF_FFFF);
    rd_reg(2'd0, v); chk("R2 control masks", 64'(v), 64'hC010_00FF);
    rd_reg(2'd3, v); chk("R2 unused address", 64'(v), 64'd0);

    // R9 disabled go and go-clear writes
    wr_reg(2'd0, 32'h0000_0001);
    prep_phy(1'b0, 16'h0, 1'b0);
    wr_reg(2'd1, cmd_word(1'b1, 1'b1, 5'd3, 5'd4, 16'h1234));
    repeat (40) @(negedge clk);
    chk("R9 no MDC when disabled", 64'(nrise), 64'd0);
    rd_reg(2'd1, v); chk("R9 command unchanged when disabled", 64'(v), 64'd0);
    wr_reg(2'd0, 32'h4000_0001);
    wr_reg(2'd1, cmd_word(1'b0, 1'b1, 5'd3, 5'd4, 16'h1234));
    repeat (40) @(negedge clk);
    chk("R9 no MDC without go", 64'(nrise), 64'd0);
    rd_reg(2'd1, v); chk("R9 command unchanged without go", 64'(v), 64'd0);

    // R4 MDC widths, div 4 -> period 5, high 2, low 3
    txn(1'b1, 5'd1, 5'd2, 16'hBEEF, 1'b0, 16'h0, 4, 1'b0);
    chk("R4 MDC high width", 64'(last_hi), 64'd2);
    chk("R4 MDC low width", 64'(last_lo), 64'd3);
    chk("R4 MDC idle low", 64'(mdc), 64'd0);

    // R7 presence set then cleared
    txn(1'b0, 5'd31, 5'd1, 16'h0, 1'b1, 16'h796D, 1, 1'b0);
    txn(1'b0, 5'd0, 5'd2, 16'h0, 1'b1, 16'h8001, 0, 1'b1);
    txn(1'b0, 5'd31, 5'd1, 16'h0, 1'b0, 16'h0, 1, 1'b0);
    txn(1'b1, 5'd0, 5'd9, 16'h0F0F, 1'b0, 16'h0, 2, 1'b0);

    // R8 writes while busy, and R2 idle bit during a frame
    wr_reg(2'd0, 32'h4000_0001);
    prep_phy(1'b0, 16'h0, 1'b0);
    wr_reg(2'd1, cmd_word(1'b1, 1'b1, 5'd5, 5'd9, 16'hA5A5));
    rd_reg(2'd0, v); chk("R2 idle clear while busy", 64'(v[31]), 64'd0);
    wr_reg(2'd1, cmd_word(1'b1, 1'b0, 5'd17, 5'd22, 16'h0000));
    wr_reg(2'd0, 32'h4010_0007);
    reg_addr = 2'd1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!reg_rdata[31]) break;
    end
    v = reg_rdata;
    chk("R8 command fields kept", 64'(v), 64'(cmd_word(1'b0, 1'b1, 5'd5, 5'd9, 16'hA5A5)));
    chk("R8 frame unchanged", 64'(nrise), 64'd64);
    check_frame(1'b1, 5'd5, 5'd9, 16'hA5A5, 64);
    rd_reg(2'd0, v); chk("R8 control kept", 64'(v), 64'hC000_0001);

    // random mix
    for (int t = 0; t < 24; t++) begin
      bit          w, r, s;
      logic [4:0]  p, a;
      logic [15:0] d, pd;
      int          dv;
      w  = 1'($urandom);
      r  = 1'($urandom);
      s  = (($urandom % 4) == 0);
      p  = 5'($urandom);
      a  = 5'($urandom);
      d  = 16'($urandom);
      pd = 16'($urandom);
      dv = $urandom % 4;
      txn(w, p, a, d, r, pd, dv, s);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule